// File: doc/BRIEF.md
# Colour Lookup Table with Host Register Port

This block stores the colour palette of an indexed-colour display. It holds 256 pixel entries and four overlay entries for the cursor. Each entry has separate 8-bit red, green and blue parts. The host reaches the table through three 32-bit registers: an index register, a pixel data port and an overlay data port. Every data access walks through red, green and blue in turn. After the blue step the index moves on by one, so a host can load or dump a whole palette with a single index write followed by a stream of data accesses.

The pixel pipeline has its own read-only lookup port. It presents a 9-bit entry number and gets the 24-bit colour back one cycle later. Entries 0 to 255 are the pixel palette and entries 256 to 259 are the overlay colours. Writes to any other register offset are accepted and do nothing.

Top module: `clut_host_port`

## Requirements
- R1: A write to offset 0 loads the index from write-data bits 31:24 and returns the component step to red, even in the middle of a triplet.
- R2: Successive writes to offset 4 store red, then green, then blue into pixel entry `index`, each taken from write-data bits 31:24. Bits 23:0 of the write data are ignored.
- R3: After the blue step of any data access (read or write), the index increases by one and the step returns to red.
- R4: A read of offset 4 returns the current component of pixel entry `index` in bits 31:24, with bits 23:0 zero. The value appears on `host_rdata` in the cycle after the read strobe, and successive reads follow the same red, green, blue order.
- R5: The index advance wraps from 255 to 0.
- R6: Writes to offset 12 go to overlay entry 256 + index[1:0] and leave the pixel entry `index` untouched. They still advance the sequencer as in R3.
- R7: After reset every entry is black (0,0,0), except entries 255, 256 and 258, which are white (255,255,255). The index and step start at 0 and red.
- R8: A read of offset 12 returns pixel entry `index`, exactly as offset 4 does. A read of any other offset returns zero and leaves the index and step unchanged. `host_rdata` is zero in every cycle that does not follow a data read.
- R9: A write to any offset other than 0, 4 and 12 changes no entry, no index and no step. If a write and a read are strobed in the same cycle, only the write takes effect.
- R10: The lookup port is registered. One cycle after `lu_entry` is presented, `lu_rgb` holds {red[23:16], green[15:8], blue[7:0]} of that entry. Entry numbers 260 and above return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_addr | input | ADDR_W (6) | Byte offset of the register |
| host_wdata | input | DATA_W (32) | Write data; the component sits in the top byte |
| host_rdata | output | DATA_W (32) | Read data, valid the cycle after a read strobe |
| lu_entry | input | 9 | Entry number requested by the pixel pipeline |
| lu_rgb | output | 24 | Colour of the requested entry, one cycle later |

## Verification
The hardest state to reach from the ports is a sequencer that is out of step with an access the host makes at the same moment. Examples are an index reload in the middle of a triplet, a write to an ignored offset between the red and green steps, and the blue step that carries the index from 255 back to 0. Only a sequence of several accesses in a set order reaches these states. Each directed task therefore builds the exact access sequence needed to reach one of them. The bench's own model tracks the index and step, and the task reads the result back through the lookup port or the data port. Overlay aliasing is checked the same way: the task writes through offset 12 and then reads the target entry, and also the pixel entry of the same index that must stay unchanged.

// File: rtl/clut_pkg.sv
// Shared constants, step encoding and reset colours for the colour lookup table.
// Assumes: an 8-bit component, 256 pixel entries, 4 overlay entries after them.
package clut_pkg;

    localparam int COMP_W      = 8;
    localparam int PIX_ENTRIES = 256;
    localparam int OVL_ENTRIES = 4;
    localparam int ALL_ENTRIES = PIX_ENTRIES + OVL_ENTRIES;
    localparam int ENTRY_W     = $clog2(ALL_ENTRIES);
    localparam int IDX_W       = $clog2(PIX_ENTRIES);
    localparam int OVL_SEL_W   = $clog2(OVL_ENTRIES);
    localparam int NUM_COMP    = 3;

    // Register offsets; the host software depends on these.
    localparam int OFF_INDEX   = 0;
    localparam int OFF_PIXEL   = 4;
    localparam int OFF_OVERLAY = 12;

    // Component step of the triplet sequencer; the value selects the colour plane.
    typedef enum logic [1:0] {
        STEP_RED = 2'd0,
        STEP_GRN = 2'd1,
        STEP_BLU = 2'd2
    } step_e;

    // Reset level of one component of entry e: white for 255, 256 and 258.
    function automatic logic [COMP_W-1:0] reset_level(input int e);
        return (e == 255 || e == 256 || e == 258) ? {COMP_W{1'b1}} : {COMP_W{1'b0}};
    endfunction

endpackage

// File: rtl/clut_plane.sv
// One colour component of every table entry (red, green or blue).
// One write port, one combinational host read port and one registered lookup port.
// Assumes: addresses at or above ENTRIES read as zero and are never written.
module clut_plane #(
    parameter int ENTRIES = clut_pkg::ALL_ENTRIES,
    parameter int EW      = clut_pkg::ENTRY_W,
    parameter int CW      = clut_pkg::COMP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [EW-1:0] waddr,
    input  logic [CW-1:0] wdata,
    input  logic [EW-1:0] haddr,
    output logic [CW-1:0] hdata,
    input  logic [EW-1:0] laddr,
    output logic [CW-1:0] ldata
);

    logic [CW-1:0] mem [ENTRIES];

    // Storage: loads reset colours, then takes one component write per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem[i] <= clut_pkg::reset_level(i);
            end
        end else if (we && (int'(waddr) < ENTRIES)) begin
            mem[waddr] <= wdata;
        end
    end

    // Host read: combinational select for the sequencer read path.
    always_comb begin
        hdata = (int'(haddr) < ENTRIES) ? mem[haddr] : '0;
    end

    // Lookup read: one-cycle registered output for the pixel pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ldata <= '0;
        end else begin
            ldata <= (int'(laddr) < ENTRIES) ? mem[laddr] : '0;
        end
    end

endmodule

// File: rtl/clut_seq.sv
// Index register and red/green/blue step sequencer of the host port.
// Decodes offsets and produces one-hot component write enables, the target
// entry, and the read request. Assumes at most one strobe is honoured per
// cycle: a write masks a read.
module clut_seq #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr,
    input  logic                                rd,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [DATA_W-1:0]                   wdata,
    output logic [clut_pkg::NUM_COMP-1:0]       comp_we,
    output logic [clut_pkg::ENTRY_W-1:0]        wr_entry,
    output logic [clut_pkg::COMP_W-1:0]         wr_byte,
    output logic [clut_pkg::ENTRY_W-1:0]        rd_entry,
    output logic                                rd_go,
    output logic [clut_pkg::IDX_W-1:0]          idx_o,
    output clut_pkg::step_e                     step_o
);
    import clut_pkg::*;

    localparam int TOP_LSB = DATA_W - COMP_W;

    logic [IDX_W-1:0] idx_q;
    step_e            step_q;
    logic             hit_index, hit_pixel, hit_overlay, hit_data;
    logic             data_wr, data_rd, advance;

    // Offset decode: exact match on the byte offset.
    always_comb begin
        hit_index   = (addr == ADDR_W'(OFF_INDEX));
        hit_pixel   = (addr == ADDR_W'(OFF_PIXEL));
        hit_overlay = (addr == ADDR_W'(OFF_OVERLAY));
        hit_data    = hit_pixel || hit_overlay;
        data_wr     = wr && hit_data;
        data_rd     = rd && !wr && hit_data;
        advance     = data_wr || data_rd;
    end

    // Index and step state: index load, or step advance with wrap after blue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            step_q <= STEP_RED;
        end else if (wr && hit_index) begin
            idx_q  <= wdata[DATA_W-1 -: IDX_W];
            step_q <= STEP_RED;
        end else if (advance) begin
            case (step_q)
                STEP_RED: step_q <= STEP_GRN;
                STEP_GRN: step_q <= STEP_BLU;
                default: begin
                    step_q <= STEP_RED;
                    idx_q  <= idx_q + 1'b1;
                end
            endcase
        end
    end

    // Write target: overlay entries alias through the low index bits.
    always_comb begin
        if (hit_overlay) begin
            wr_entry = ENTRY_W'(PIX_ENTRIES) + ENTRY_W'(idx_q[OVL_SEL_W-1:0]);
        end else begin
            wr_entry = ENTRY_W'(idx_q);
        end
        wr_byte  = wdata[TOP_LSB +: COMP_W];
        rd_entry = ENTRY_W'(idx_q);
        rd_go    = data_rd;
    end

    // Component write enables: one plane per step.
    generate
        for (genvar k = 0; k < NUM_COMP; k++) begin : g_we
            assign comp_we[k] = data_wr && (step_q == step_e'(k));
        end
    endgenerate

    assign idx_o  = idx_q;
    assign step_o = step_q;

endmodule

// File: rtl/clut_host_port.sv
// Colour lookup table top: host register port plus a pixel lookup port.
// Three component planes share one sequencer. Host reads return the current
// component in the top byte, registered one cycle after the strobe.
// Assumes single-cycle strobes and 32-bit accesses only.
module clut_host_port #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          host_wr,
    input  logic                                          host_rd,
    input  logic [ADDR_W-1:0]                             host_addr,
    input  logic [DATA_W-1:0]                             host_wdata,
    output logic [DATA_W-1:0]                             host_rdata,
    input  logic [clut_pkg::ENTRY_W-1:0]                  lu_entry,
    output logic [clut_pkg::NUM_COMP*clut_pkg::COMP_W-1:0] lu_rgb
);
    import clut_pkg::*;

    localparam int PAD_W = DATA_W - COMP_W;

    logic [NUM_COMP-1:0]             comp_we;
    logic [ENTRY_W-1:0]              wr_entry, rd_entry;
    logic [COMP_W-1:0]               wr_byte;
    logic                            rd_go;
    logic [IDX_W-1:0]                seq_idx;
    step_e                           seq_step;
    logic [1:0]                      seq_step_bits;
    logic [NUM_COMP-1:0][COMP_W-1:0] hdata;
    logic [NUM_COMP-1:0][COMP_W-1:0] ldata;

    clut_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (host_wr),
        .rd       (host_rd),
        .addr     (host_addr),
        .wdata    (host_wdata),
        .comp_we  (comp_we),
        .wr_entry (wr_entry),
        .wr_byte  (wr_byte),
        .rd_entry (rd_entry),
        .rd_go    (rd_go),
        .idx_o    (seq_idx),
        .step_o   (seq_step)
    );

    assign seq_step_bits = seq_step;

    // Planes: index 0 red, 1 green, 2 blue (matches the step encoding).
    generate
        for (genvar k = 0; k < NUM_COMP; k++) begin : g_plane
            clut_plane #(
                .ENTRIES (ALL_ENTRIES),
                .EW      (ENTRY_W),
                .CW      (COMP_W)
            ) u_plane (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (comp_we[k]),
                .waddr (wr_entry),
                .wdata (wr_byte),
                .haddr (rd_entry),
                .hdata (hdata[k]),
                .laddr (lu_entry),
                .ldata (ldata[k])
            );
            assign lu_rgb[(NUM_COMP-1-k)*COMP_W +: COMP_W] = ldata[k];
        end
    endgenerate

    // Read data: current component in the top byte after a data read, else zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (rd_go) begin
            host_rdata <= {hdata[seq_step_bits], {PAD_W{1'b0}}};
        end else begin
            host_rdata <= '0;
        end
    end

endmodule

// File: rtl/clut_host_port_chk.sv
// Protocol checks for the colour lookup table host port, bound to the top.
module clut_host_port_chk #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic              host_rd,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DATA_W-1:0] host_wdata,
    input logic [DATA_W-1:0] host_rdata,
    input logic [2:0]        comp_we,
    input logic [7:0]        seq_idx,
    input logic [1:0]        seq_step
);

    logic is_idx, is_data;
    assign is_idx  = (host_addr == ADDR_W'(0));
    assign is_data = (host_addr == ADDR_W'(4)) || (host_addr == ADDR_W'(12));

    // R1
    idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && is_idx) |=> (seq_idx == $past(host_wdata[DATA_W-1 -: 8]) && seq_step == 2'd0));

    // R2
    red_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == ADDR_W'(4) && seq_step == 2'd0) |-> (comp_we == 3'b001));

    // R3
    idx_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && is_data && seq_step == 2'd2) |=> (seq_idx == $past(seq_idx) + 8'd1 && seq_step == 2'd0));

    // R4
    rdata_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[DATA_W-9:0] == '0);

    // R8
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd && !host_wr && is_data) |=> (host_rdata == '0));

    // R9
    ignored_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !is_idx && !is_data) |=> ($stable(seq_idx) && $stable(seq_step)));

endmodule

bind clut_host_port clut_host_port_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .comp_we    (comp_we),
    .seq_idx    (seq_idx),
    .seq_step   (seq_step_bits)
);

// File: tb/clut_host_port_tb.sv
// Directed bench for the colour lookup table, with its own reference model.
module clut_host_port_tb;

    localparam int AW = 6;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_wr, host_rd;
    logic [AW-1:0] host_addr;
    logic [31:0] host_wdata;
    logic [31:0] host_rdata;
    logic [8:0]  lu_entry;
    logic [23:0] lu_rgb;

    int n_run  = 0;
    int n_fail = 0;

    // Reference model
    logic [7:0] m_r [260];
    logic [7:0] m_g [260];
    logic [7:0] m_b [260];
    logic [7:0] m_idx;
    int         m_step;

    always #10 clk = ~clk;

    clut_host_port #(.ADDR_W(AW), .DATA_W(32)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .lu_entry   (lu_entry),
        .lu_rgb     (lu_rgb)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic void m_reset();
        for (int i = 0; i < 260; i++) begin
            m_r[i] = (i == 255 || i == 256 || i == 258) ? 8'hFF : 8'h00;
            m_g[i] = m_r[i];
            m_b[i] = m_r[i];
        end
        m_idx  = 8'd0;
        m_step = 0;
    endfunction

    function automatic void m_advance();
        if (m_step == 2) begin
            m_step = 0;
            m_idx  = m_idx + 8'd1;
        end else begin
            m_step++;
        end
    endfunction

    // Host write with junk in the low bytes, mirrored into the model.
    task automatic do_wr(input int off, input logic [7:0] val);
        int e;
        @(negedge clk);
        host_wr    = 1'b1;
        host_addr  = AW'(off);
        host_wdata = {val, 24'hA5C3E1};
        @(negedge clk);
        host_wr    = 1'b0;
        if (off == 0) begin
            m_idx  = val;
            m_step = 0;
        end else if (off == 4 || off == 12) begin
            e = (off == 12) ? 256 + int'(m_idx[1:0]) : int'(m_idx);
            if (m_step == 0) m_r[e] = val;
            else if (m_step == 1) m_g[e] = val;
            else m_b[e] = val;
            m_advance();
        end
    endtask

    // Host read, compared with the model's expectation.
    task automatic do_rd(input int off, input string req);
        logic [31:0] exp;
        exp = 32'h0;
        if (off == 4 || off == 12) begin
            if (m_step == 0) exp = {m_r[m_idx], 24'h0};
            else if (m_step == 1) exp = {m_g[m_idx], 24'h0};
            else exp = {m_b[m_idx], 24'h0};
            m_advance();
        end
        @(negedge clk);
        host_rd   = 1'b1;
        host_addr = AW'(off);
        @(negedge clk);
        host_rd   = 1'b0;
        check(req, host_rdata, exp);
    endtask

    task automatic lu_check(input int e, input string req);
        logic [23:0] exp;
        exp = (e < 260) ? {m_r[e], m_g[e], m_b[e]} : 24'h0;
        @(negedge clk);
        lu_entry = 9'(e);
        @(negedge clk);
        check(req, {8'h0, lu_rgb}, {8'h0, exp});
    endtask

    task automatic t_reset();
        check("R7 rdata after reset", host_rdata, 32'h0);
        foreach (m_r[i]) begin
            if (i < 2 || i > 253) lu_check(i, "R7 reset colour");
        end
        do_wr(0, 8'd255);
        do_rd(4, "R7 read white 255");
        do_rd(4, "R7 read white 255");
    endtask

    task automatic t_write_seq();
        do_wr(0, 8'd5);
        do_wr(4, 8'h11); do_wr(4, 8'h22); do_wr(4, 8'h33);
        lu_check(5, "R2 triplet stored");
        do_wr(4, 8'h44); do_wr(4, 8'h55); do_wr(4, 8'h66);
        lu_check(6, "R3 next entry after blue");
    endtask

    task automatic t_read_seq();
        do_wr(0, 8'd5);
        for (int k = 0; k < 3; k++) do_rd(4, "R4 read component");
        do_rd(4, "R3 read advances index");
        do_rd(4, "R4 read green of next");
    endtask

    task automatic t_wrap();
        do_wr(0, 8'd255);
        do_wr(4, 8'h81); do_wr(4, 8'h82); do_wr(4, 8'h83);
        do_wr(4, 8'h91); do_wr(4, 8'h92); do_wr(4, 8'h93);
        lu_check(255, "R5 entry 255");
        lu_check(0, "R5 wrapped to entry 0");
        do_wr(0, 8'd255);
        for (int k = 0; k < 4; k++) do_rd(4, "R5 read across wrap");
    endtask

    task automatic t_overlay();
        do_wr(0, 8'h06);
        do_wr(12, 8'h12); do_wr(12, 8'h34); do_wr(12, 8'h56);
        lu_check(258, "R6 overlay alias 258");
        lu_check(6, "R6 pixel entry untouched");
        lu_check(259, "R6 other overlay untouched");
        do_wr(12, 8'hC1); do_wr(12, 8'hC2); do_wr(12, 8'hC3);
        lu_check(259, "R6 alias after advance");
        do_wr(0, 8'h06);
        do_rd(12, "R8 overlay read hits pixel");
        do_rd(12, "R8 overlay read hits pixel");
    endtask

    task automatic t_restart();
        do_wr(0, 8'd10);
        do_wr(4, 8'h77);
        do_wr(0, 8'd10);
        do_wr(4, 8'h01); do_wr(4, 8'h02); do_wr(4, 8'h03);
        lu_check(10, "R1 index reload restarts red");
    endtask

    task automatic t_ignored();
        do_wr(0, 8'd20);
        do_wr(4, 8'hAA);
        do_wr(8, 8'hFF);
        do_wr(16, 8'hEE);
        do_wr(2, 8'hDD);
        do_wr(4, 8'hBB); do_wr(4, 8'hCC);
        lu_check(20, "R9 ignored offsets");
        lu_check(21, "R9 neighbour intact");
        do_wr(0, 8'd20);
        do_rd(4, "R8 read red");
        do_rd(0, "R8 read offset 0 zero");
        do_rd(8, "R8 read offset 8 zero");
        do_rd(4, "R8 other reads keep step");
        // Simultaneous strobes: write wins, read ignored.
        @(negedge clk);
        host_wr = 1'b1; host_rd = 1'b1; host_addr = AW'(4); host_wdata = {8'h5E, 24'h0};
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        m_b[20] = 8'h5E; m_step = 0; m_idx = m_idx + 8'd1;
        check("R9 no read data with write", host_rdata, 32'h0);
        lu_check(20, "R9 write wins over read");
    endtask

    task automatic t_lookup();
        lu_check(300, "R10 out of range zero");
        lu_check(511, "R10 top entry zero");
        lu_check(257, "R10 overlay via lookup");
        lu_check(5, "R10 pixel via lookup");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; host_wr = 1'b0; host_rd = 1'b0;
        host_addr = '0; host_wdata = '0; lu_entry = '0;
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_seq();
        t_read_seq();
        t_wrap();
        t_overlay();
        t_restart();
        t_ignored();
        t_lookup();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule